// File: doc/BRIEF.md
# USB Root Port Change-Status Tracker

This block keeps the sticky status-change flags of a two-port USB host root hub and runs the timed line sequences that produce two of them. Software asks for a port reset or a port resume, and the block asserts the matching line-drive request for the required time. When a sequence finishes, the block raises the corresponding change flag. Over-current indicator changes and enable losses caused by hardware are detected from level inputs and also raise flags. Software reads each port's 32-bit status word and clears flags by writing ones to that word's byte address.

All timing comes from the system clock. A per-port millisecond divider (`MS_DIV` clocks per millisecond) restarts at the beginning of each timed phase. The low-speed end-of-packet phase lasts two low-speed bit times of `LS_BIT_DIV` clocks each. A reset request that arrives during any resume phase cancels the resume and starts the reset timer.

Top module: `usb_rport_chg`

## Requirements
- R1: After synchronous reset, both status words read 0 and all line-drive requests are low.
- R2: Each status word holds its flags at fixed positions: reset-complete at bit 20, over-current change at bit 19, resume-complete at bit 18, and enable change at bit 17. All other bits read 0. Port 0 is written at byte address 0x54 and port 1 at 0x58.
- R3: A reset request on an idle port raises `drv_reset` on the next cycle and holds it for exactly `RST_MS*MS_DIV` cycles (10 ms). Bit 20 becomes set one cycle after `drv_reset` falls.
- R4: A resume request on an idle port runs three phases in order. `drv_resume` is high for `RSM_MS*MS_DIV` cycles. `drv_ls_eop` is then high for `2*LS_BIT_DIV` cycles. A quiet wait of `RSYNC_MS*MS_DIV` cycles follows. Bit 18 becomes set one cycle after that wait ends.
- R5: A change of `oc_ind` in either direction sets bit 19 of that port one cycle later.
- R6: A fall of `en_state` while `en_hw_cause` is 1 sets bit 17 one cycle later. A fall while `en_hw_cause` is 0 leaves bit 17 unchanged.
- R7: A write to a port's address clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. Writes to any other address leave that port's flags unchanged.
- R8: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: In the cycle where bit 20 becomes set, bit 18 of the same port is cleared.
- R10: A reset request during a resume phase drops the resume drives on the next cycle and starts a full-length reset, and the resume flag is not set. Reset or resume requests made while a reset is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | NPORT | Per-port request to start a port reset |
| resume_req | input | NPORT | Per-port request to start a port resume |
| oc_ind | input | NPORT | Per-port over-current indicator level |
| en_state | input | NPORT | Per-port enable state level |
| en_hw_cause | input | NPORT | Qualifies an enable fall as caused by hardware |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data (1 bits clear flags) |
| status_o | output | NPORT x 32 | Per-port status words |
| drv_reset | output | NPORT | Request to drive reset signalling on the port |
| drv_resume | output | NPORT | Request to drive resume signalling on the port |
| drv_ls_eop | output | NPORT | Request to drive the low-speed end-of-packet |

## Verification
Directed runs measure each timed phase cycle by cycle. These runs cover a reset on its own, a full resume, a resume followed by a reset (which shows that reset completion clears the resume flag), and a resume cut short by a reset with further requests arriving mid-reset (which separates an abort from a restart). Separate directed steps cover over-current toggles in both directions, enable falls with and without a hardware cause, and a set colliding with a clear. A seeded random phase then mixes indicator flips, enable changes and writes to valid and invalid addresses with random data. It compares both status words every cycle against a bench model, so a clear that is lost, leaks to the wrong port, or beats a set is caught.

// File: rtl/usb_rport_pkg.sv
package usb_rport_pkg;

    localparam int unsigned STAT_W  = 32;
    localparam int unsigned BIT_PRC = 20;
    localparam int unsigned BIT_OCC = 19;
    localparam int unsigned BIT_RSC = 18;
    localparam int unsigned BIT_ENC = 17;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RESET,
        PH_RESUME,
        PH_EOP,
        PH_RESYNC
    } phase_e;

    typedef struct packed {
        logic rst_done;
        logic rsm_done;
        logic oc_chg;
        logic en_loss;
    } chg_ev_t;

    typedef struct packed {
        logic prc;
        logic occ;
        logic rsc;
        logic enc;
    } chg_flags_t;

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(chg_flags_t f);
        logic [STAT_W-1:0] w;
        w          = '0;
        w[BIT_PRC] = f.prc;
        w[BIT_OCC] = f.occ;
        w[BIT_RSC] = f.rsc;
        w[BIT_ENC] = f.enc;
        return w;
    endfunction

endpackage

// File: rtl/usb_rport_timer.sv
module usb_rport_timer #(
    parameter int unsigned MS_DIV  = 48000,
    parameter int unsigned EOP_CLK = 64,
    parameter int unsigned MS_W    = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic            eop_mode,
    input  logic [MS_W-1:0] len_ms,
    output logic            last
);
    import usb_rport_pkg::*;

    localparam int unsigned SUB_MAX = umax(MS_DIV, EOP_CLK);
    localparam int unsigned SUB_W   = $clog2(SUB_MAX + 1);

    logic [SUB_W-1:0] sub_q;
    logic [MS_W-1:0]  ms_q;
    logic             sub_end;
    logic             ms_end;

    always_comb begin
        sub_end = eop_mode ? (sub_q == SUB_W'(EOP_CLK - 1))
                           : (sub_q == SUB_W'(MS_DIV - 1));
        ms_end  = (ms_q == (len_ms - MS_W'(1)));
    end

    assign last = run && sub_end && (eop_mode || ms_end);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            sub_q <= '0;
            ms_q  <= '0;
        end else if (sub_end) begin
            sub_q <= '0;
            ms_q  <= ms_q + MS_W'(1);
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

endmodule

// File: rtl/usb_rport_seq.sv
module usb_rport_seq #(
    parameter int unsigned MS_DIV     = 48000,
    parameter int unsigned LS_BIT_DIV = 32,
    parameter int unsigned RST_MS     = 10,
    parameter int unsigned RSM_MS     = 20,
    parameter int unsigned RSYNC_MS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_req,
    input  logic resume_req,
    output logic drv_reset,
    output logic drv_resume,
    output logic drv_ls_eop,
    output logic rst_done,
    output logic rsm_done
);
    import usb_rport_pkg::*;

    localparam int unsigned EOP_CLK = 2 * LS_BIT_DIV;
    localparam int unsigned MS_MAX  = umax(RST_MS, umax(RSM_MS, RSYNC_MS));
    localparam int unsigned MS_W    = $clog2(MS_MAX + 1);

    phase_e          st_q;
    phase_e          st_n;
    logic            restart;
    logic            last;
    logic [MS_W-1:0] len_ms;

    always_comb begin
        case (st_q)
            PH_RESET:  len_ms = MS_W'(RST_MS);
            PH_RESUME: len_ms = MS_W'(RSM_MS);
            PH_RESYNC: len_ms = MS_W'(RSYNC_MS);
            default:   len_ms = MS_W'(1);
        endcase
    end

    usb_rport_timer #(
        .MS_DIV (MS_DIV),
        .EOP_CLK(EOP_CLK),
        .MS_W   (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q != PH_IDLE),
        .restart (restart),
        .eop_mode(st_q == PH_EOP),
        .len_ms  (len_ms),
        .last    (last)
    );

    always_comb begin
        st_n    = st_q;
        restart = 1'b0;
        case (st_q)
            PH_IDLE: begin
                if (reset_req) begin
                    st_n    = PH_RESET;
                    restart = 1'b1;
                end else if (resume_req) begin
                    st_n    = PH_RESUME;
                    restart = 1'b1;
                end
            end
            PH_RESET: begin
                if (last) begin
                    st_n = PH_IDLE;
                end
            end
            PH_RESUME, PH_EOP, PH_RESYNC: begin
                if (reset_req) begin
                    st_n    = PH_RESET;
                    restart = 1'b1;
                end else if (last) begin
                    restart = 1'b1;
                    case (st_q)
                        PH_RESUME: st_n = PH_EOP;
                        PH_EOP:    st_n = PH_RESYNC;
                        default:   st_n = PH_IDLE;
                    endcase
                end
            end
            default: st_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= PH_IDLE;
            rst_done <= 1'b0;
            rsm_done <= 1'b0;
        end else begin
            st_q     <= st_n;
            rst_done <= (st_q == PH_RESET) && last;
            rsm_done <= (st_q == PH_RESYNC) && last && !reset_req;
        end
    end

    assign drv_reset  = (st_q == PH_RESET);
    assign drv_resume = (st_q == PH_RESUME);
    assign drv_ls_eop = (st_q == PH_EOP);

endmodule

// File: rtl/usb_rport_evdet.sv
module usb_rport_evdet (
    input  logic clk,
    input  logic rst,
    input  logic oc_ind,
    input  logic en_state,
    input  logic en_hw_cause,
    output logic oc_chg,
    output logic en_loss
);
    logic oc_q;
    logic en_q;
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        oc_q       <= oc_ind;
        en_q       <= en_state;
        rst_seen_q <= rst;
    end

    assign oc_chg  = !rst_seen_q && (oc_q != oc_ind);
    assign en_loss = !rst_seen_q && en_q && !en_state && en_hw_cause;

endmodule

// File: rtl/usb_rport_flags.sv
module usb_rport_flags #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned PORT_ADDR = 8'h54
) (
    input  logic                                clk,
    input  logic                                rst,
    input  usb_rport_pkg::chg_ev_t              ev,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [usb_rport_pkg::STAT_W-1:0]    wr_data,
    output usb_rport_pkg::chg_flags_t           flags
);
    import usb_rport_pkg::*;

    logic       hit;
    chg_flags_t clr;
    chg_flags_t nxt;
    logic       unused_wr_bits;

    assign hit = wr_en && (wr_addr == ADDR_W'(PORT_ADDR));
    assign unused_wr_bits = ^{wr_data[STAT_W-1:BIT_PRC+1], wr_data[BIT_ENC-1:0]};

    always_comb begin
        clr.prc = hit && wr_data[BIT_PRC];
        clr.occ = hit && wr_data[BIT_OCC];
        clr.rsc = hit && wr_data[BIT_RSC];
        clr.enc = hit && wr_data[BIT_ENC];

        nxt.prc = ev.rst_done | (flags.prc & ~clr.prc);
        nxt.occ = ev.oc_chg   | (flags.occ & ~clr.occ);
        nxt.enc = ev.en_loss  | (flags.enc & ~clr.enc);
        if (ev.rst_done) begin
            nxt.rsc = 1'b0;
        end else begin
            nxt.rsc = ev.rsm_done | (flags.rsc & ~clr.rsc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= nxt;
        end
    end

endmodule

// File: rtl/usb_rport_chg.sv
module usb_rport_chg #(
    parameter int unsigned NPORT       = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PORT_BASE   = 8'h54,
    parameter int unsigned PORT_STRIDE = 4,
    parameter int unsigned MS_DIV      = 48000,
    parameter int unsigned LS_BIT_DIV  = 32,
    parameter int unsigned RST_MS      = 10,
    parameter int unsigned RSM_MS      = 20,
    parameter int unsigned RSYNC_MS    = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        reset_req,
    input  logic [NPORT-1:0]        resume_req,
    input  logic [NPORT-1:0]        oc_ind,
    input  logic [NPORT-1:0]        en_state,
    input  logic [NPORT-1:0]        en_hw_cause,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    output logic [NPORT-1:0][31:0]  status_o,
    output logic [NPORT-1:0]        drv_reset,
    output logic [NPORT-1:0]        drv_resume,
    output logic [NPORT-1:0]        drv_ls_eop
);
    import usb_rport_pkg::*;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam int unsigned P_ADDR = PORT_BASE + i * PORT_STRIDE;

        chg_ev_t    ev;
        chg_flags_t flags;

        usb_rport_seq #(
            .MS_DIV    (MS_DIV),
            .LS_BIT_DIV(LS_BIT_DIV),
            .RST_MS    (RST_MS),
            .RSM_MS    (RSM_MS),
            .RSYNC_MS  (RSYNC_MS)
        ) u_seq (
            .clk       (clk),
            .rst       (rst),
            .reset_req (reset_req[i]),
            .resume_req(resume_req[i]),
            .drv_reset (drv_reset[i]),
            .drv_resume(drv_resume[i]),
            .drv_ls_eop(drv_ls_eop[i]),
            .rst_done  (ev.rst_done),
            .rsm_done  (ev.rsm_done)
        );

        usb_rport_evdet u_evdet (
            .clk        (clk),
            .rst        (rst),
            .oc_ind     (oc_ind[i]),
            .en_state   (en_state[i]),
            .en_hw_cause(en_hw_cause[i]),
            .oc_chg     (ev.oc_chg),
            .en_loss    (ev.en_loss)
        );

        usb_rport_flags #(
            .ADDR_W   (ADDR_W),
            .PORT_ADDR(P_ADDR)
        ) u_flags (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .flags  (flags)
        );

        assign status_o[i] = pack_status(flags);
    end

endmodule

// File: rtl/usb_rport_chk.sv
module usb_rport_chk #(
    parameter int unsigned NPORT       = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PORT_BASE   = 8'h54,
    parameter int unsigned PORT_STRIDE = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NPORT-1:0]        oc_ind,
    input logic [NPORT-1:0]        en_state,
    input logic [NPORT-1:0]        en_hw_cause,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [31:0]             wr_data,
    input logic [NPORT-1:0][31:0]  status_o,
    input logic [NPORT-1:0]        drv_reset,
    input logic [NPORT-1:0]        drv_resume,
    input logic [NPORT-1:0]        drv_ls_eop
);
    logic unused_chk_bits;
    assign unused_chk_bits = ^{wr_data[31:20], wr_data[18:0]};

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] P_ADDR = ADDR_W'(PORT_BASE + i * PORT_STRIDE);

        // R3
        drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({drv_reset[i], drv_resume[i], drv_ls_eop[i]}));

        // R3
        rst_done_flag_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(drv_reset[i]) |=> status_o[i][20]);

        // R4
        resume_to_eop_chk: assert property (@(posedge clk) disable iff (rst)
            ($fell(drv_resume[i]) && !drv_reset[i]) |-> drv_ls_eop[i]);

        // R9
        rst_clears_rsm_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(status_o[i][20]) |-> !status_o[i][18]);

        // R5
        oc_change_chk: assert property (@(posedge clk) disable iff (rst)
            (oc_ind[i] != $past(oc_ind[i])) |=> status_o[i][19]);

        // R6
        en_loss_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(en_state[i]) && !en_state[i] && en_hw_cause[i]) |=> status_o[i][17]);

        // R7
        write_zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_addr == P_ADDR) && !wr_data[19] && status_o[i][19])
            |=> status_o[i][19]);
    end

endmodule

bind usb_rport_chg usb_rport_chk #(
    .NPORT      (NPORT),
    .ADDR_W     (ADDR_W),
    .PORT_BASE  (PORT_BASE),
    .PORT_STRIDE(PORT_STRIDE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .oc_ind     (oc_ind),
    .en_state   (en_state),
    .en_hw_cause(en_hw_cause),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .status_o   (status_o),
    .drv_reset  (drv_reset),
    .drv_resume (drv_resume),
    .drv_ls_eop (drv_ls_eop)
);

// File: tb/usb_rport_chg_tb.sv
module usb_rport_chg_tb;

    localparam int unsigned NPORT      = 2;
    localparam int unsigned MS_DIV     = 8;
    localparam int unsigned LS_BIT_DIV = 3;
    localparam int unsigned RST_LEN    = 10 * MS_DIV;
    localparam int unsigned RSM_LEN    = 20 * MS_DIV;
    localparam int unsigned EOP_LEN    = 2 * LS_BIT_DIV;
    localparam int unsigned RSYNC_LEN  = 3 * MS_DIV;
    localparam logic [7:0]  A0 = 8'h54;
    localparam logic [7:0]  A1 = 8'h58;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NPORT-1:0]       reset_req;
    logic [NPORT-1:0]       resume_req;
    logic [NPORT-1:0]       oc_ind;
    logic [NPORT-1:0]       en_state;
    logic [NPORT-1:0]       en_hw_cause;
    logic                   wr_en;
    logic [7:0]             wr_addr;
    logic [31:0]            wr_data;
    logic [NPORT-1:0][31:0] status_o;
    logic [NPORT-1:0]       drv_reset;
    logic [NPORT-1:0]       drv_resume;
    logic [NPORT-1:0]       drv_ls_eop;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_rport_chg #(
        .NPORT     (NPORT),
        .MS_DIV    (MS_DIV),
        .LS_BIT_DIV(LS_BIT_DIV)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .reset_req  (reset_req),
        .resume_req (resume_req),
        .oc_ind     (oc_ind),
        .en_state   (en_state),
        .en_hw_cause(en_hw_cause),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .status_o   (status_o),
        .drv_reset  (drv_reset),
        .drv_resume (drv_resume),
        .drv_ls_eop (drv_ls_eop)
    );

    // Expected status word from flags {reset-done, oc-change, resume-done, enable-change}
    function automatic logic [31:0] word(logic [3:0] f);
        return {11'b0, f, 17'b0};
    endfunction

    function automatic logic sticky(logic q, logic set, logic clr);
        return set | (q & ~clr);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_rst(int p);
        reset_req[p] = 1'b1;
        cyc();
        reset_req[p] = 1'b0;
    endtask

    task automatic pulse_rsm(int p);
        resume_req[p] = 1'b1;
        cyc();
        resume_req[p] = 1'b0;
    endtask

    // Counts cycles (sampled at negedges) while drv_reset of port p is high
    task automatic count_reset(int p, output int n);
        n = 0;
        while (drv_reset[p]) begin
            n++;
            cyc();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] mf [NPORT];
        logic       ocp [NPORT];
        logic       enp [NPORT];
        logic [7:0] addr_pick [4];

        void'($urandom(32'd7331));
        rst = 1'b1; reset_req = '0; resume_req = '0; oc_ind = '0;
        en_state = '1; en_hw_cause = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (5) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        chk("R1 status0", status_o[0], 32'h0);
        chk("R1 status1", status_o[1], 32'h0);
        chk("R1 drives", {29'b0, |drv_reset, |drv_resume, |drv_ls_eop}, 32'h0);

        // R3 reset length and flag timing
        pulse_rst(0);
        count_reset(0, n);
        chk("R3 reset length", n, RST_LEN);
        chk("R3 flag not yet", status_o[0], 32'h0);
        cyc();
        chk("R3 R2 flag bit20", status_o[0], word(4'b1000));
        chk("R2 other port untouched", status_o[1], 32'h0);

        // R7 write-1-clear, write-0 keep, wrong address keep
        wr(A0, 32'h0);
        chk("R7 write zero keeps", status_o[0], word(4'b1000));
        wr(A1, 32'h0010_0000);
        chk("R7 other port address keeps", status_o[0], word(4'b1000));
        wr(8'h50, 32'hFFFF_FFFF);
        chk("R7 foreign address keeps", status_o[0], word(4'b1000));
        wr(A0, 32'h0010_0000);
        chk("R7 write one clears", status_o[0], 32'h0);

        // R4 resume phases
        pulse_rsm(0);
        n = 0;
        while (drv_resume[0]) begin n++; cyc(); end
        chk("R4 resume length", n, RSM_LEN);
        chk("R4 eop follows", {31'b0, drv_ls_eop[0]}, 32'h1);
        n = 0;
        while (drv_ls_eop[0]) begin n++; cyc(); end
        chk("R4 eop length", n, EOP_LEN);
        // quiet wait, plus one cycle for the flag register
        n = 0;
        while (!status_o[0][18] && n < 1000) begin n++; cyc(); end
        chk("R4 resync wait", n, RSYNC_LEN + 1);
        chk("R4 R2 flag bit18", status_o[0], word(4'b0010));

        // R9 reset completion clears resume flag
        pulse_rst(0);
        chk("R9 resume flag held during reset", status_o[0], word(4'b0010));
        count_reset(0, n);
        cyc();
        chk("R9 reset done clears resume", status_o[0], word(4'b1000));
        wr(A0, 32'hFFFF_FFFF);
        chk("R7 clear all port0", status_o[0], 32'h0);

        // R10 abort resume on port 1, requests during reset ignored
        pulse_rsm(1);
        repeat (30) cyc();
        chk("R10 resume running", {31'b0, drv_resume[1]}, 32'h1);
        pulse_rst(1);
        chk("R10 abort drives", {30'b0, drv_reset[1], drv_resume[1]}, 32'h2);
        n = 0;
        while (drv_reset[1]) begin
            n++;
            reset_req[1]  = (n == 20);
            resume_req[1] = (n == 20);
            cyc();
        end
        reset_req[1] = 1'b0; resume_req[1] = 1'b0;
        chk("R10 reset not restarted", n, RST_LEN);
        cyc();
        chk("R10 no resume flag", status_o[1], word(4'b1000));
        repeat (RSM_LEN + 40) cyc();
        chk("R10 resume request ignored", {29'b0, drv_reset[1], drv_resume[1], drv_ls_eop[1]}, 32'h0);
        chk("R10 flags stable", status_o[1], word(4'b1000));
        wr(A1, 32'hFFFF_FFFF);
        chk("R7 clear all port1", status_o[1], 32'h0);

        // R5 over-current indicator change in both directions
        oc_ind[0] = 1'b1;
        cyc();
        chk("R5 rising toggle", status_o[0], word(4'b0100));
        wr(A0, 32'h0008_0000);
        chk("R5 cleared", status_o[0], 32'h0);
        oc_ind[0] = 1'b0;
        cyc();
        chk("R5 falling toggle", status_o[0], word(4'b0100));
        wr(A0, 32'h0008_0000);

        // R6 enable loss with and without hardware cause
        en_state[0] = 1'b0; en_hw_cause[0] = 1'b0;
        cyc();
        chk("R6 software disable ignored", status_o[0], 32'h0);
        en_state[0] = 1'b1;
        cyc();
        chk("R6 re-enable no flag", status_o[0], 32'h0);
        en_state[0] = 1'b0; en_hw_cause[0] = 1'b1;
        cyc();
        en_hw_cause[0] = 1'b0;
        chk("R6 hardware loss sets", status_o[0], word(4'b0001));
        wr(A0, 32'h0002_0000);
        chk("R6 cleared", status_o[0], 32'h0);

        // R8 set wins over clear in the same cycle
        oc_ind[1] = 1'b1;
        wr_en = 1'b1; wr_addr = A1; wr_data = 32'h0008_0000;
        cyc();
        wr_en = 1'b0;
        chk("R8 set beats clear from zero", status_o[1], word(4'b0100));
        oc_ind[1] = 1'b0;
        wr_en = 1'b1; wr_addr = A1; wr_data = 32'h0008_0000;
        cyc();
        wr_en = 1'b0;
        chk("R8 set beats clear when set", status_o[1], word(4'b0100));
        wr(A1, 32'hFFFF_FFFF);
        chk("R8 cleared afterwards", status_o[1], 32'h0);

        // Random mix of events and writes against the bench model
        addr_pick[0] = A0; addr_pick[1] = A1; addr_pick[2] = 8'h50; addr_pick[3] = 8'h5C;
        for (int p = 0; p < NPORT; p++) begin
            mf[p] = 4'b0; ocp[p] = oc_ind[p]; enp[p] = en_state[p];
        end
        for (int it = 0; it < 400; it++) begin
            for (int p = 0; p < NPORT; p++) begin
                if ($urandom % 6 == 0) oc_ind[p] = ~oc_ind[p];
                if ($urandom % 5 == 0) en_state[p] = ~en_state[p];
                en_hw_cause[p] = 1'($urandom % 2);
            end
            wr_en   = ($urandom % 3 == 0);
            wr_addr = addr_pick[$urandom % 4];
            wr_data = $urandom;
            for (int p = 0; p < NPORT; p++) begin
                logic hit;
                logic oc_ev;
                logic en_ev;
                hit   = wr_en && (wr_addr == ((p == 0) ? A0 : A1));
                oc_ev = (oc_ind[p] != ocp[p]);
                en_ev = enp[p] && !en_state[p] && en_hw_cause[p];
                mf[p][3] = sticky(mf[p][3], 1'b0,  hit && wr_data[20]);
                mf[p][2] = sticky(mf[p][2], oc_ev, hit && wr_data[19]);
                mf[p][1] = sticky(mf[p][1], 1'b0,  hit && wr_data[18]);
                mf[p][0] = sticky(mf[p][0], en_ev, hit && wr_data[17]);
                ocp[p] = oc_ind[p];
                enp[p] = en_state[p];
            end
            cyc();
            chk("R7 R8 random port0", status_o[0], word(mf[0]));
            chk("R7 R8 random port1", status_o[1], word(mf[1]));
        end
        wr_en = 1'b0;
        cyc();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule